// File: doc/BRIEF.md
# Clock-only command sequencer

This block reads a stream of command bytes over a valid/ready byte interface and runs the commands that toggle a serial clock without moving data. Each clock pulse is requested from an external pulse timer, one at a time. The sequencer then waits for that timer's done strobe before it decides whether another pulse is needed. Commands differ in how they stop:

- after a counted number of pulses, given in bits or in groups of eight;
- when a monitored input reaches a chosen level;
- at whichever of the count or the level comes first.

Two further commands only wait for a monitor level and emit no clock. A flush command produces a single-cycle strobe for the response path. Any unrecognised opcode produces a single-cycle error strobe, and the next byte is read as a fresh opcode.

A level wait can hang for ever if the awaited level never appears. Dropping the enable input is the escape: it returns the sequencer to opcode fetch from any state.

Top module: `clk_burst_seq`

## Requirements
- R1: While reset is active or after reset, busy_o, pulse_req_o, flush_o and bad_cmd_o are low, and cmd_ready_o equals en_i.
- R2: Opcode 0x8E takes one operand byte and produces (operand[2:0] + 1) pulses. Operand bits 7:3 have no effect.
- R3: Opcode 0x8F takes a low byte and then a high byte, forming a 16-bit value L, and produces 8 × (L + 1) pulses.
- R4: Opcode 0x88 waits until the synchronized monitor is 1, and opcode 0x89 waits until it is 0. Neither produces a pulse, and a wait whose level is already present completes without a pulse.
- R5: Opcode 0x94 pulses until the monitor is 1, and 0x95 pulses until it is 0. The level is tested only between pulses. pulse_req_o stays high from its rise until pulse_done_i, so every started pulse completes.
- R6: Opcodes 0x9C (stop on 1) and 0x9D (stop on 0) take a low byte and then a high byte, forming L. They produce 8 × (L + 1) pulses, or fewer if the monitor reaches the stop level first.
- R7: With en_i low, the next cycle has busy_o and pulse_req_o low, from any state, including a hung wait or a pulse in progress. After en_i rises again, the next byte is taken as an opcode.
- R8: Accepting opcode 0x87 raises flush_o for exactly the following cycle. busy_o stays low.
- R9: Accepting an opcode that is not listed here raises bad_cmd_o for exactly the following cycle. The next byte accepted is decoded as an opcode.
- R10: busy_o is high from the cycle after an opcode is accepted until the command completes. cmd_ready_o is high only while fetching an opcode (busy_o low) or an operand byte, and is low while a pulse or a level wait is in progress.
- R11: The monitor input passes through a two-flop synchronizer before any level decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable; low aborts any command |
| cmd_data_i | input | 8 | Command byte (opcode or operand) |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_ready_o | output | 1 | Sequencer accepts a byte this cycle |
| mon_i | input | 1 | Asynchronous monitor level input |
| pulse_req_o | output | 1 | Request one clock pulse from the pulse timer |
| pulse_done_i | input | 1 | Pulse timer reports the requested pulse finished |
| flush_o | output | 1 | One-cycle flush strobe |
| bad_cmd_o | output | 1 | One-cycle unknown-opcode strobe |
| busy_o | output | 1 | A command is in progress |

## Verification
The assertions assume the pulse timer behaves. It raises pulse_done_i only while pulse_req_o is high, and for a single cycle per pulse. From that they derive that the pulse budget never decrements past zero and that a requested pulse is held until it is acknowledged. The bench's timer model gates its done strobe with the request and clears it after one cycle, so it never acknowledges a pulse that was not asked for. The bench holds the monitor level for several cycles before each command that tests it, which absorbs the synchronizer delay. Early-stop cases are checked as bounds, not exact counts.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

  localparam logic [7:0] OP_FLUSH     = 8'h87;
  localparam logic [7:0] OP_WAIT_HI   = 8'h88;
  localparam logic [7:0] OP_WAIT_LO   = 8'h89;
  localparam logic [7:0] OP_CLK_BITS  = 8'h8E;
  localparam logic [7:0] OP_CLK_BYTES = 8'h8F;
  localparam logic [7:0] OP_RUN_HI    = 8'h94;
  localparam logic [7:0] OP_RUN_LO    = 8'h95;
  localparam logic [7:0] OP_CNT_HI    = 8'h9C;
  localparam logic [7:0] OP_CNT_LO    = 8'h9D;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_ARG_LO,
    ST_ARG_HI,
    ST_LEVEL,
    ST_DECIDE,
    ST_PULSE
  } seq_state_e;

  typedef struct packed {
    logic known;
    logic flush;
    logic level_only;
    logic counted;
    logic two_arg;
    logic stop_on_lvl;
    logic stop_lvl;
  } cmd_info_t;

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[TOP-1:0], d_i};
  end

  assign q_o = sr_q[TOP];
endmodule

// File: rtl/op_decode.sv
module op_decode
  import clk_seq_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_info_t  info_o
);
  always_comb begin
    info_o = '0;
    case (op_i)
      OP_FLUSH:     begin info_o.known = 1'b1; info_o.flush = 1'b1; end
      OP_WAIT_HI:   begin info_o.known = 1'b1; info_o.level_only = 1'b1; info_o.stop_lvl = 1'b1; end
      OP_WAIT_LO:   begin info_o.known = 1'b1; info_o.level_only = 1'b1; end
      OP_CLK_BITS:  begin info_o.known = 1'b1; info_o.counted = 1'b1; end
      OP_CLK_BYTES: begin info_o.known = 1'b1; info_o.counted = 1'b1; info_o.two_arg = 1'b1; end
      OP_RUN_HI:    begin info_o.known = 1'b1; info_o.stop_on_lvl = 1'b1; info_o.stop_lvl = 1'b1; end
      OP_RUN_LO:    begin info_o.known = 1'b1; info_o.stop_on_lvl = 1'b1; end
      OP_CNT_HI: begin
        info_o.known = 1'b1; info_o.counted = 1'b1; info_o.two_arg = 1'b1;
        info_o.stop_on_lvl = 1'b1; info_o.stop_lvl = 1'b1;
      end
      OP_CNT_LO: begin
        info_o.known = 1'b1; info_o.counted = 1'b1; info_o.two_arg = 1'b1;
        info_o.stop_on_lvl = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pulse_budget.sv
module pulse_budget #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_bits_i,
  input  logic             load_bytes_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             zero_o
);
  // byte mode needs (2^LEN_W) * 8 pulses at most
  localparam int CNT_W = LEN_W + 4;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (load_bits_i)  cnt_q <= CNT_W'(len_i[2:0]) + CNT_W'(1);
    else if (load_bytes_i) cnt_q <= (CNT_W'(len_i) + CNT_W'(1)) << 3;
    else if (dec_i)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
endmodule

// File: rtl/clk_burst_seq.sv
module clk_burst_seq
  import clk_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] cmd_data_i,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic       mon_i,
  output logic       pulse_req_o,
  input  logic       pulse_done_i,
  output logic       flush_o,
  output logic       bad_cmd_o,
  output logic       busy_o
);
  localparam int LEN_W = 16;

  seq_state_e st_q, st_d;
  cmd_info_t  dec_info;
  logic       counted_q, two_arg_q, stop_on_lvl_q, stop_lvl_q;
  logic [7:0] lo_q;
  logic       flush_q, bad_q;
  logic       mon_s, lvl_hit, accept, fetch_acc;
  logic       load_bits, load_bytes, dec, cnt_zero;
  logic [LEN_W-1:0] len_sel;

  mon_sync #(.STAGES(SYNC_STAGES)) u_mon_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mon_i),
    .q_o   (mon_s)
  );

  op_decode u_op_decode (
    .op_i  (cmd_data_i),
    .info_o(dec_info)
  );

  assign len_sel = (st_q == ST_ARG_HI) ? {cmd_data_i, lo_q} : {8'h00, cmd_data_i};

  pulse_budget #(.LEN_W(LEN_W)) u_pulse_budget (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (!en_i),
    .load_bits_i (load_bits),
    .load_bytes_i(load_bytes),
    .len_i       (len_sel),
    .dec_i       (dec),
    .zero_o      (cnt_zero)
  );

  assign cmd_ready_o = en_i && (st_q == ST_FETCH || st_q == ST_ARG_LO || st_q == ST_ARG_HI);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign fetch_acc   = accept && (st_q == ST_FETCH);
  assign busy_o      = (st_q != ST_FETCH);
  assign pulse_req_o = (st_q == ST_PULSE);
  assign lvl_hit     = (mon_s == stop_lvl_q);
  assign flush_o     = flush_q;
  assign bad_cmd_o   = bad_q;

  always_comb begin
    st_d       = st_q;
    load_bits  = 1'b0;
    load_bytes = 1'b0;
    dec        = 1'b0;
    case (st_q)
      ST_FETCH: begin
        if (fetch_acc && dec_info.known && !dec_info.flush) begin
          if (dec_info.level_only)   st_d = ST_LEVEL;
          else if (dec_info.counted) st_d = ST_ARG_LO;
          else                       st_d = ST_DECIDE;
        end
      end
      ST_ARG_LO: begin
        if (accept) begin
          if (two_arg_q) st_d = ST_ARG_HI;
          else begin
            load_bits = 1'b1;
            st_d      = ST_DECIDE;
          end
        end
      end
      ST_ARG_HI: begin
        if (accept) begin
          load_bytes = 1'b1;
          st_d       = ST_DECIDE;
        end
      end
      ST_LEVEL: if (lvl_hit) st_d = ST_FETCH;
      ST_DECIDE: begin
        // stop conditions are only evaluated between pulses
        if (stop_on_lvl_q && lvl_hit)     st_d = ST_FETCH;
        else if (counted_q && cnt_zero)   st_d = ST_FETCH;
        else                              st_d = ST_PULSE;
      end
      ST_PULSE: begin
        if (pulse_done_i) begin
          dec  = counted_q;
          st_d = ST_DECIDE;
        end
      end
      default: st_d = ST_FETCH;
    endcase
    if (!en_i) st_d = ST_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_FETCH;
      counted_q      <= 1'b0;
      two_arg_q      <= 1'b0;
      stop_on_lvl_q  <= 1'b0;
      stop_lvl_q     <= 1'b0;
      lo_q           <= '0;
      flush_q        <= 1'b0;
      bad_q          <= 1'b0;
    end else begin
      st_q    <= st_d;
      flush_q <= fetch_acc && dec_info.flush;
      bad_q   <= fetch_acc && !dec_info.known;
      if (fetch_acc) begin
        counted_q     <= dec_info.counted;
        two_arg_q     <= dec_info.two_arg;
        stop_on_lvl_q <= dec_info.stop_on_lvl;
        stop_lvl_q    <= dec_info.stop_lvl;
      end
      if (accept && st_q == ST_ARG_LO) lo_q <= cmd_data_i;
    end
  end

  assert_done_on_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_done_i |-> pulse_req_o);

  assert_pulse_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_req_o && !pulse_done_i && en_i) |=> pulse_req_o);

  assert_disable_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !pulse_req_o));

  assert_flush_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(cmd_valid_i && cmd_ready_o && !busy_o && cmd_data_i == OP_FLUSH));

  assert_bad_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cmd_o |-> $past(cmd_valid_i && cmd_ready_o && !busy_o));

  assert_no_fetch_in_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_req_o) |-> !$past(cmd_ready_o && cmd_valid_i && !busy_o));
endmodule

// File: tb/clk_burst_seq_bench.sv
module clk_burst_seq_bench;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [1:0]  nargs;
    logic        mon;
    logic [3:0]  req;
    logic [19:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{8'h8E, 8'h07, 8'h00, 2'd1, 1'b0, 4'd2, 20'd8},     // R2 max bit count
    '{8'h8E, 8'h00, 8'h00, 2'd1, 1'b0, 4'd2, 20'd1},     // R2 min
    '{8'h8E, 8'hFA, 8'h00, 2'd1, 1'b0, 4'd2, 20'd3},     // R2 upper bits ignored
    '{8'h8F, 8'h00, 8'h00, 2'd2, 1'b0, 4'd3, 20'd8},     // R3 zero length
    '{8'h8F, 8'h02, 8'h01, 2'd2, 1'b1, 4'd3, 20'd2072},  // R3 low byte first
    '{8'h9C, 8'h00, 8'h00, 2'd2, 1'b0, 4'd6, 20'd8},     // R6 count wins
    '{8'h9D, 8'h01, 8'h00, 2'd2, 1'b1, 4'd6, 20'd16},    // R6 count wins
    '{8'h9C, 8'h05, 8'h00, 2'd2, 1'b1, 4'd6, 20'd0},     // R6 level already present
    '{8'h94, 8'h00, 8'h00, 2'd0, 1'b1, 4'd5, 20'd0},     // R5 level already present
    '{8'h95, 8'h00, 8'h00, 2'd0, 1'b0, 4'd5, 20'd0},     // R5 level already present
    '{8'h88, 8'h00, 8'h00, 2'd0, 1'b1, 4'd4, 20'd0},     // R4 no clock
    '{8'h89, 8'h00, 8'h00, 2'd0, 1'b0, 4'd4, 20'd0}      // R4 no clock
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, valid = 1'b0, mon = 1'b0;
  logic [7:0] data = 8'h00;
  logic ready, preq, flush, bad, busy, pdone, done_w, preq_q;
  int checks = 0, fails = 0, pulses = 0, rises = 0, cyc = 0;

  always #2 clk = ~clk;

  assign done_w = pdone & preq;

  clk_burst_seq u_clk_burst_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .cmd_data_i  (data),
    .cmd_valid_i (valid),
    .cmd_ready_o (ready),
    .mon_i       (mon),
    .pulse_req_o (preq),
    .pulse_done_i(done_w),
    .flush_o     (flush),
    .bad_cmd_o   (bad),
    .busy_o      (busy)
  );

  // pulse timer model: done one cycle after request, for one cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdone  <= 1'b0;
      preq_q <= 1'b0;
    end else begin
      pdone  <= preq & ~pdone;
      preq_q <= preq;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (preq && done_w) pulses++;
    if (preq && !preq_q) rises++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R7 cycles actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    data  = b;
    valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    @(negedge clk);
    while (busy && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int base, base_r, got;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "ready in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pulse_req after reset", preq, 0);
    check("R1", "flush/bad after reset", {flush, bad}, 0);
    check("R1", "ready with en low", ready, 0);
    en = 1'b1;
    @(negedge clk);
    check("R1", "ready with en high", ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      mon = VEC[i].mon;
      repeat (4) @(negedge clk);
      base = pulses;
      send_byte(VEC[i].op);
      if (VEC[i].nargs > 0) send_byte(VEC[i].lo);
      if (VEC[i].nargs > 1) send_byte(VEC[i].hi);
      wait_idle(20000);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d done", i), busy, 0);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d pulses", i), pulses - base, VEC[i].exp);
    end

    // R8 flush strobe
    send_byte(8'h87);
    @(negedge clk);
    check("R8", "flush high", flush, 1);
    check("R8", "busy during flush", busy, 0);
    @(negedge clk);
    check("R8", "flush one cycle", flush, 0);

    // R9 unknown opcode, then next byte is an opcode
    send_byte(8'h42);
    @(negedge clk);
    check("R9", "bad high", bad, 1);
    @(negedge clk);
    check("R9", "bad one cycle", bad, 0);
    base = pulses;
    send_byte(8'h8E);
    send_byte(8'h02);
    wait_idle(100);
    check("R9", "opcode after bad", pulses - base, 3);

    // R10 busy and ready during operands and pulses
    send_byte(8'h8F);
    check("R10", "busy after opcode", busy, 1);
    send_byte(8'h00);
    send_byte(8'h00);
    @(negedge clk);
    @(negedge clk);
    check("R10", "ready low while pulsing", ready, 0);
    wait_idle(200);

    // R4 hang on level, then release
    mon = 1'b0;
    repeat (4) @(negedge clk);
    base = pulses;
    send_byte(8'h88);
    repeat (40) @(negedge clk);
    check("R4", "wait hangs", busy, 1);
    check("R4", "wait no clock", pulses - base, 0);
    mon = 1'b1;
    wait_idle(10);
    check("R11", "released via sync", busy, 0);

    // R7 escape a hung wait by disabling
    send_byte(8'h89);
    repeat (20) @(negedge clk);
    check("R7", "hung wait busy", busy, 1);
    en = 1'b0;
    @(negedge clk);
    check("R7", "disable clears busy", busy, 0);
    check("R7", "ready low disabled", ready, 0);
    en = 1'b1;

    // R5 run until level
    mon = 1'b0;
    repeat (4) @(negedge clk);
    base = pulses;
    base_r = rises;
    send_byte(8'h94);
    repeat (30) @(negedge clk);
    mon = 1'b1;
    wait_idle(50);
    check("R5", "run stopped", busy, 0);
    check("R5", "run pulsed", (pulses - base) >= 5, 1);
    check("R5", "every pulse completed", rises - base_r, pulses - base);

    // R6 early stop on level
    mon = 1'b1;
    repeat (4) @(negedge clk);
    base = pulses;
    send_byte(8'h9D);
    send_byte(8'h10);
    send_byte(8'h00);
    repeat (30) @(negedge clk);
    mon = 1'b0;
    wait_idle(500);
    got = pulses - base;
    check("R6", "early stop bound", (got > 0 && got < 136), 1);

    // R7 disable in the middle of a pulse train, then resume
    mon = 1'b0;
    repeat (4) @(negedge clk);
    send_byte(8'h94);
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R7", "pulse_req cleared", preq, 0);
    check("R7", "busy cleared", busy, 0);
    en = 1'b1;
    base = pulses;
    send_byte(8'h8E);
    send_byte(8'h00);
    wait_idle(50);
    check("R7", "resume fetch", pulses - base, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule